// File: doc/BRIEF.md
# Three-Phase Sine-Triangle PWM Modulator

This block produces active-high gate commands for a three-leg inverter bridge. Each leg has an upper and a lower switch. A shared symmetric triangle carrier runs from -PEAK to +PEAK and back once every PERIOD clock cycles. At the default 50 MHz clock and PERIOD of 8192, this gives a switching frequency of about 6103.5 Hz. Each leg has a signed reference sample, where +1.0 is the integer PEAK (8192 by default). The reference is multiplied by a modulation index and then compared with the carrier on every cycle, so an edge can be placed to within one clock (20 ns).

A leg drives its upper switch while its scaled reference is above the carrier, and its lower switch otherwise. After every change of a leg's command, a programmable dead band holds both switches of that leg off. The references, the modulation index and the mode select are taken only when the carrier is at its valley, so a pulse is never reshaped in the middle of a period. In the H-bridge mode only legs A and B switch and leg C is held off. The run enable doubles as an emergency stop: dropping it turns every gate off on the next clock.

Top module: `pwm3_modulator`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, all six gate outputs are low. The carrier restarts at its valley (-PEAK), rising.
- R2: The carrier is a symmetric triangle between -PEAK and +PEAK, stepping by 4*PEAK/PERIOD each cycle. One full period is PERIOD cycles. With steady inputs, the rising edges of a leg's upper gate are exactly PERIOD cycles apart.
- R3: Scaled level = floor(ref * mod_idx / 2^MI_FRAC). A leg is commanded high when its scaled level is strictly greater than the carrier, and low otherwise. The gates follow the command through one output register, minus the dead band.
- R4: ref_a, ref_b, ref_c, mod_idx and hbridge_sel are sampled only on the cycle the carrier is at -PEAK, and take effect on the next cycle. A change at any other time has no effect on the outputs until that sample.
- R5: The upper and lower gates of one leg are never high in the same cycle.
- R6: After any change of a leg's command, both of its gates stay low for dead_ticks+1 cycles before the new gate is driven. This gives a gap of exactly dead_ticks+1 cycles between a lower gate falling and the upper gate rising.
- R7: When run_en is low at a clock edge, all six gates are low after that edge. After run_en returns high, each leg waits out the dead band of R6 before driving a gate.
- R8: When hbridge_sel (bit value 1) is in effect, leg C (gate bit 2) keeps both gates low, while legs A (bit 0) and B (bit 1) keep switching from their own references.
- R9: mod_idx is unsigned with MI_FRAC fraction bits (256 is unity by default). A reference of +PEAK at half index switches like a reference of +PEAK/2 at unity index. An index of 0 gives a scaled level of 0.
- R10: A scaled level above +PEAK keeps the leg's upper gate high for whole periods with no lower pulse (overmodulation).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Modulator clock, one carrier tick per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | Active-high run enable and emergency stop |
| hbridge_sel | input | 1 | 1 = single-phase H-bridge on legs A and B, 0 = three-phase |
| ref_a | input | REF_W | Signed reference for leg A, +PEAK is unity |
| ref_b | input | REF_W | Signed reference for leg B |
| ref_c | input | REF_W | Signed reference for leg C |
| mod_idx | input | MI_W | Unsigned modulation index, MI_FRAC fraction bits |
| dead_ticks | input | DT_W | Extra dead-band cycles after each command change |
| gate_up | output | 3 | Upper switch commands, bit 0 = leg A, bit 2 = leg C |
| gate_dn | output | 3 | Lower switch commands, bit 0 = leg A, bit 2 = leg C |

## Verification
The dead-band assertions assume that dead_ticks is held steady while any leg is switching, because the count is loaded at the moment a command changes. The stimulus therefore changes dead_ticks only while run_en is low and every gate is off. The reference model likewise assumes that the product of reference and index fits the internal width. For this reason, stimulus keeps references within about ±1.25 of unity and the index below 2.0. Mid-period changes of references, index and mode are applied on purpose, so that the valley-only sampling is exercised against the model on every cycle.

// File: rtl/pwm3_pkg.sv
package pwm3_pkg;

   typedef enum logic [1:0] {
      CMD_OFF = 2'b00,
      CMD_LO  = 2'b01,
      CMD_HI  = 2'b10
   } leg_cmd_e;

   localparam int unsigned NUM_LEGS = 3;
   localparam int unsigned LEG_C    = 2;

endpackage

// File: rtl/pwm3_tri_carrier.sv
module pwm3_tri_carrier
   import pwm3_pkg::*;
#(
   parameter int PEAK   = 8192,
   parameter int PERIOD = 8192,
   parameter int CAR_W  = 15
) (
   input  logic                    clk,
   input  logic                    rst_n,
   output logic signed [CAR_W-1:0] car,
   output logic                    valley
);

   localparam int STEP = (4 * PEAK) / PERIOD;
   localparam logic signed [CAR_W-1:0] TOP    = CAR_W'(PEAK);
   localparam logic signed [CAR_W-1:0] BOT    = -TOP;
   localparam logic signed [CAR_W-1:0] STEP_V = CAR_W'(STEP);

   if (STEP < 1 || (4 * PEAK) % PERIOD != 0) begin : g_bad_step
      $error("carrier: PERIOD must divide 4*PEAK with a step of at least 1");
   end
   if ((2 * PEAK) % STEP != 0) begin : g_bad_span
      $error("carrier: step must divide the peak-to-peak span");
   end

   logic rising_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         car      <= BOT;
         rising_q <= 1'b1;
      end else if (rising_q) begin
         if (car + STEP_V >= TOP) begin
            car      <= TOP;
            rising_q <= 1'b0;
         end else begin
            car <= car + STEP_V;
         end
      end else begin
         if (car - STEP_V <= BOT) begin
            car      <= BOT;
            rising_q <= 1'b1;
         end else begin
            car <= car - STEP_V;
         end
      end
   end

   assign valley = (car == BOT);

   // R2
   car_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (car <= TOP) && (car >= BOT));

   // R2
   peak_turn_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (car == TOP) |=> (car == TOP - STEP_V));

   // R2
   valley_turn_chk: assert property (@(posedge clk) disable iff (!rst_n)
      valley |=> (car == BOT + STEP_V));

endmodule

// File: rtl/pwm3_ref_scale.sv
module pwm3_ref_scale
   import pwm3_pkg::*;
#(
   parameter int REF_W         = 16,
   parameter int MI_W          = 9,
   parameter int MI_FRAC       = 8,
   parameter int LVL_W         = 26,
   parameter bit ROUND_NEAREST = 1'b0
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    valley,
   input  logic signed [REF_W-1:0] ref_in [NUM_LEGS],
   input  logic [MI_W-1:0]         mi_in,
   input  logic                    mode_in,
   output logic signed [LVL_W-1:0] lvl [NUM_LEGS],
   output logic                    mode_q
);

   if (MI_FRAC < 1 || MI_FRAC >= MI_W) begin : g_bad_frac
      $error("scale: MI_FRAC must lie in 1..MI_W-1");
   end
   if (LVL_W < REF_W + MI_W + 1) begin : g_bad_lvl
      $error("scale: LVL_W too narrow for the product");
   end

   localparam logic signed [LVL_W-1:0] HALF_LSB = LVL_W'(1) <<< (MI_FRAC - 1);

   logic signed [REF_W-1:0] ref_q [NUM_LEGS];
   logic [MI_W-1:0]         mi_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mi_q   <= '0;
         mode_q <= 1'b0;
      end else if (valley) begin
         mi_q   <= mi_in;
         mode_q <= mode_in;
      end
   end

   for (genvar g = 0; g < NUM_LEGS; g++) begin : g_leg
      logic signed [LVL_W-1:0] prod;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            ref_q[g] <= '0;
         end else if (valley) begin
            ref_q[g] <= ref_in[g];
         end
      end

      assign prod = LVL_W'(ref_q[g]) * LVL_W'($signed({1'b0, mi_q}));

      if (ROUND_NEAREST) begin : g_round
         assign lvl[g] = (prod + HALF_LSB) >>> MI_FRAC;
      end else begin : g_floor
         assign lvl[g] = prod >>> MI_FRAC;
      end

      // R4
      ref_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !valley |=> $stable(ref_q[g]));

      // R4
      ref_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
         valley |=> (ref_q[g] == $past(ref_in[g])));
   end

   // R4
   mi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !valley |=> ($stable(mi_q) && $stable(mode_q)));

   // R4
   mi_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
      valley |=> (mi_q == $past(mi_in)));

endmodule

// File: rtl/pwm3_dead_band.sv
module pwm3_dead_band
   import pwm3_pkg::*;
#(
   parameter int DT_W = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  leg_cmd_e        cmd,
   input  logic [DT_W-1:0] gap,
   output logic            g_up,
   output logic            g_dn
);

   leg_cmd_e        cmd_q;
   logic [DT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_q <= CMD_OFF;
         cnt_q <= '0;
         g_up  <= 1'b0;
         g_dn  <= 1'b0;
      end else if (cmd != cmd_q) begin
         cmd_q <= cmd;
         cnt_q <= gap;
         g_up  <= 1'b0;
         g_dn  <= 1'b0;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
         g_up  <= 1'b0;
         g_dn  <= 1'b0;
      end else begin
         g_up  <= (cmd_q == CMD_HI);
         g_dn  <= (cmd_q == CMD_LO);
      end
   end

   // R5
   no_shoot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(g_up && g_dn));

   // R6
   up_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(g_up) |-> !$past(g_dn));

   // R6
   dn_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(g_dn) |-> !$past(g_up));

   // R7
   off_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == CMD_OFF) |=> (!g_up && !g_dn));

endmodule

// File: rtl/pwm3_modulator.sv
module pwm3_modulator
   import pwm3_pkg::*;
#(
   parameter int PEAK          = 8192,
   parameter int PERIOD        = 8192,
   parameter int REF_W         = 16,
   parameter int MI_W          = 9,
   parameter int MI_FRAC       = 8,
   parameter int DT_W          = 4,
   parameter bit ROUND_NEAREST = 1'b0
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    run_en,
   input  logic                    hbridge_sel,
   input  logic signed [REF_W-1:0] ref_a,
   input  logic signed [REF_W-1:0] ref_b,
   input  logic signed [REF_W-1:0] ref_c,
   input  logic [MI_W-1:0]         mod_idx,
   input  logic [DT_W-1:0]         dead_ticks,
   output logic [2:0]              gate_up,
   output logic [2:0]              gate_dn
);

   localparam int CAR_W = $clog2(PEAK) + 2;
   localparam int LVL_W = REF_W + MI_W + 1;

   if (PEAK < 2 || PERIOD < 4) begin : g_bad_size
      $error("modulator: PEAK and PERIOD too small");
   end
   if ((64'd1 << (REF_W - 1)) <= 64'(PEAK)) begin : g_bad_ref
      $error("modulator: REF_W cannot hold +PEAK");
   end
   if (LVL_W < CAR_W) begin : g_bad_cmp
      $error("modulator: level narrower than carrier");
   end

   logic signed [CAR_W-1:0] car;
   logic                    valley;
   logic signed [LVL_W-1:0] car_ext;
   logic signed [REF_W-1:0] ref_arr [NUM_LEGS];
   logic signed [LVL_W-1:0] lvl [NUM_LEGS];
   logic                    mode_q;

   assign ref_arr[0] = ref_a;
   assign ref_arr[1] = ref_b;
   assign ref_arr[2] = ref_c;
   assign car_ext    = LVL_W'(car);

   pwm3_tri_carrier #(
      .PEAK   (PEAK),
      .PERIOD (PERIOD),
      .CAR_W  (CAR_W)
   ) u_carrier (
      .clk    (clk),
      .rst_n  (rst_n),
      .car    (car),
      .valley (valley)
   );

   pwm3_ref_scale #(
      .REF_W         (REF_W),
      .MI_W          (MI_W),
      .MI_FRAC       (MI_FRAC),
      .LVL_W         (LVL_W),
      .ROUND_NEAREST (ROUND_NEAREST)
   ) u_scale (
      .clk     (clk),
      .rst_n   (rst_n),
      .valley  (valley),
      .ref_in  (ref_arr),
      .mi_in   (mod_idx),
      .mode_in (hbridge_sel),
      .lvl     (lvl),
      .mode_q  (mode_q)
   );

   for (genvar g = 0; g < NUM_LEGS; g++) begin : g_leg
      leg_cmd_e cmd;
      logic     leg_off;

      if (g == LEG_C) begin : g_hb_gate
         assign leg_off = !run_en || mode_q;
      end else begin : g_plain
         assign leg_off = !run_en;
      end

      always_comb begin
         if (leg_off) begin
            cmd = CMD_OFF;
         end else if (lvl[g] > car_ext) begin
            cmd = CMD_HI;
         end else begin
            cmd = CMD_LO;
         end
      end

      pwm3_dead_band #(
         .DT_W (DT_W)
      ) u_band (
         .clk   (clk),
         .rst_n (rst_n),
         .cmd   (cmd),
         .gap   (dead_ticks),
         .g_up  (gate_up[g]),
         .g_dn  (gate_dn[g])
      );
   end

   // R7
   estop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !run_en |=> ((gate_up == 3'b000) && (gate_dn == 3'b000)));

   // R8
   hbridge_leg_c_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mode_q |=> (!gate_up[LEG_C] && !gate_dn[LEG_C]));

   // R5
   bridge_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((gate_up & gate_dn) == 3'b000));

endmodule

// File: tb/test_pwm3_modulator.sv
module test_pwm3_modulator;

   localparam int PEAK    = 64;
   localparam int PERIOD  = 64;
   localparam int REF_W   = 16;
   localparam int MI_W    = 9;
   localparam int MI_FRAC = 8;
   localparam int DT_W    = 4;
   localparam int STEP    = 4 * PEAK / PERIOD;

   logic                    clk = 1'b0;
   logic                    rst_n = 1'b0;
   logic                    run_en = 1'b0;
   logic                    hbridge_sel = 1'b0;
   logic signed [REF_W-1:0] ref_a = '0;
   logic signed [REF_W-1:0] ref_b = '0;
   logic signed [REF_W-1:0] ref_c = '0;
   logic [MI_W-1:0]         mod_idx = 9'd256;
   logic [DT_W-1:0]         dead_ticks = 4'd2;
   logic [2:0]              gate_up;
   logic [2:0]              gate_dn;

   int checks = 0;
   int fails = 0;
   int overlap = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   pwm3_modulator #(
      .PEAK    (PEAK),
      .PERIOD  (PERIOD),
      .REF_W   (REF_W),
      .MI_W    (MI_W),
      .MI_FRAC (MI_FRAC),
      .DT_W    (DT_W)
   ) i_pwm3_modulator (
      .clk         (clk),
      .rst_n       (rst_n),
      .run_en      (run_en),
      .hbridge_sel (hbridge_sel),
      .ref_a       (ref_a),
      .ref_b       (ref_b),
      .ref_c       (ref_c),
      .mod_idx     (mod_idx),
      .dead_ticks  (dead_ticks),
      .gate_up     (gate_up),
      .gate_dn     (gate_dn)
   );

   // Behavioural reference: carrier from a phase index, dead band from command age
   int         m_ph = 0;
   int         m_ref [3];
   int         m_mi = 0;
   int         m_mode = 0;
   int         m_prev [3];
   int         m_age [3];
   logic [2:0] m_up = '0;
   logic [2:0] m_dn = '0;

   function automatic int carrier_at(input int ph);
      if (ph < PERIOD / 2) return -PEAK + STEP * ph;
      return PEAK - STEP * (ph - PERIOD / 2);
   endfunction

   always @(posedge clk) begin
      int car;
      int lvl;
      int want;
      if (!rst_n) begin
         m_ph   = 0;
         m_mi   = 0;
         m_mode = 0;
         m_up   = '0;
         m_dn   = '0;
         for (int k = 0; k < 3; k++) begin
            m_ref[k]  = 0;
            m_prev[k] = 0;
            m_age[k]  = 1000;
         end
      end else begin
         car = carrier_at(m_ph);
         for (int k = 0; k < 3; k++) begin
            lvl = (m_ref[k] * m_mi) >>> MI_FRAC;
            if (!run_en || (k == 2 && m_mode != 0)) want = 0;
            else if (lvl > car) want = 2;
            else want = 1;
            if (want != m_prev[k]) begin
               m_prev[k] = want;
               m_age[k]  = 0;
            end else if (m_age[k] < 1000) begin
               m_age[k]++;
            end
            if (m_age[k] > int'(dead_ticks)) begin
               m_up[k] = (want == 2);
               m_dn[k] = (want == 1);
            end else begin
               m_up[k] = 1'b0;
               m_dn[k] = 1'b0;
            end
         end
         if (m_ph == 0) begin
            m_ref[0] = int'(ref_a);
            m_ref[1] = int'(ref_b);
            m_ref[2] = int'(ref_c);
            m_mi     = int'(mod_idx);
            m_mode   = int'(hbridge_sel);
         end
         m_ph = (m_ph + 1) % PERIOD;
      end
   end

   always @(negedge clk) begin
      if (rst_n && !done) begin
         checks++;
         if (gate_up !== m_up || gate_dn !== m_dn) begin
            fails++;
            $display("FAIL R3/R4/R6 model at %0t: actual up=%b dn=%b expected up=%b dn=%b",
                     $time, gate_up, gate_dn, m_up, m_dn);
         end
         if ((gate_up & gate_dn) != 3'b000) overlap++;
      end
   end

   task automatic check_eq(input string tag, input int act, input int exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic logic pick(input bit upper, input int leg);
      return upper ? gate_up[leg] : gate_dn[leg];
   endfunction

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wait_rise(input bit upper, input int leg);
      logic prev;
      prev = pick(upper, leg);
      for (int i = 0; i < 400; i++) begin
         @(negedge clk);
         if (!prev && pick(upper, leg)) return;
         prev = pick(upper, leg);
      end
   endtask

   task automatic wait_fall(input bit upper, input int leg);
      logic prev;
      prev = pick(upper, leg);
      for (int i = 0; i < 400; i++) begin
         @(negedge clk);
         if (prev && !pick(upper, leg)) return;
         prev = pick(upper, leg);
      end
   endtask

   task automatic pulse_width(input bit upper, input int leg, output int w);
      wait_rise(upper, leg);
      w = 1;
      for (int i = 0; i < 400; i++) begin
         @(negedge clk);
         if (!pick(upper, leg)) return;
         w++;
      end
   endtask

   task automatic rise_period(output int n);
      logic prev;
      wait_rise(1'b1, 0);
      n = 0;
      prev = 1'b1;
      for (int i = 0; i < 400; i++) begin
         @(negedge clk);
         n++;
         if (!prev && gate_up[0]) return;
         prev = gate_up[0];
      end
   endtask

   task automatic dn_to_up_gap(output int n);
      wait_fall(1'b0, 0);
      n = 1;
      for (int i = 0; i < 400; i++) begin
         @(negedge clk);
         if (gate_up[0]) return;
         n++;
      end
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
   endtask

   initial begin
      int w;
      int n;
      int sum_a;
      int sum_b;
      int sum_c;
      cyc(4);
      check_eq("R1 gates low in reset", int'({gate_up, gate_dn}), 0);
      rst_n = 1'b1;
      cyc(1);
      check_eq("R1 gates low after reset", int'({gate_up, gate_dn}), 0);
      run_en = 1'b1;
      cyc(2 * PERIOD);

      rise_period(n);
      check_eq("R2 upper edge period", n, PERIOD);
      pulse_width(1'b1, 0, w);
      check_eq("R3 upper width ref 0", w, 28);
      pulse_width(1'b0, 0, w);
      check_eq("R3 lower width ref 0", w, 30);
      dn_to_up_gap(n);
      check_eq("R6 gap dead 2", n, 3);

      ref_a = 16'sd32;
      cyc(2 * PERIOD);
      pulse_width(1'b1, 0, w);
      check_eq("R3 upper width ref +0.5", w, 44);
      ref_a = -16'sd32;
      cyc(2 * PERIOD);
      pulse_width(1'b1, 0, w);
      check_eq("R3 upper width ref -0.5", w, 12);

      // R4: change mid-period, no effect before next valley
      while (m_ph != 10) @(negedge clk);
      ref_a = 16'sd32;
      n = 0;
      for (int i = 0; i < 30; i++) begin
         @(negedge clk);
         n += int'(gate_up[0]);
      end
      check_eq("R4 mid-period change ignored", n, 0);

      ref_a = 16'sd64;
      mod_idx = 9'd128;
      cyc(2 * PERIOD);
      pulse_width(1'b1, 0, w);
      check_eq("R9 half index width", w, 44);
      mod_idx = 9'd0;
      cyc(2 * PERIOD);
      pulse_width(1'b1, 0, w);
      check_eq("R9 zero index width", w, 28);

      mod_idx = 9'd384;
      cyc(2 * PERIOD);
      sum_a = 0;
      sum_b = 0;
      for (int i = 0; i < PERIOD; i++) begin
         @(negedge clk);
         sum_a += int'(gate_up[0]);
         sum_b += int'(gate_dn[0]);
      end
      check_eq("R10 overmod upper on", sum_a, PERIOD);
      check_eq("R10 overmod lower off", sum_b, 0);

      mod_idx = 9'd256;
      ref_a = 16'sd32;
      ref_b = -16'sd32;
      ref_c = 16'sd20;
      hbridge_sel = 1'b1;
      cyc(2 * PERIOD);
      sum_a = 0;
      sum_b = 0;
      sum_c = 0;
      for (int i = 0; i < PERIOD; i++) begin
         @(negedge clk);
         sum_a += int'(gate_up[0]);
         sum_b += int'(gate_up[1]);
         sum_c += int'(gate_up[2]) + int'(gate_dn[2]);
      end
      check_eq("R8 leg C held off", sum_c, 0);
      check_eq("R8 leg A switches", int'(sum_a > 0), 1);
      check_eq("R8 leg B switches", int'(sum_b > 0), 1);
      hbridge_sel = 1'b0;
      cyc(2 * PERIOD);
      sum_c = 0;
      for (int i = 0; i < PERIOD; i++) begin
         @(negedge clk);
         sum_c += int'(gate_up[2]);
      end
      check_eq("R8 leg C back in three-phase", int'(sum_c > 0), 1);

      run_en = 1'b0;
      cyc(1);
      check_eq("R7 stop next cycle", int'({gate_up, gate_dn}), 0);
      sum_a = 0;
      for (int i = 0; i < 10; i++) begin
         @(negedge clk);
         sum_a += int'(gate_up != 0) + int'(gate_dn != 0);
      end
      check_eq("R7 held off while stopped", sum_a, 0);
      dead_ticks = 4'd0;
      ref_a = 16'sd0;
      run_en = 1'b1;
      cyc(2 * PERIOD);
      dn_to_up_gap(n);
      check_eq("R6 gap dead 0", n, 1);

      for (int i = 0; i < 60; i++) begin
         cyc(37);
         ref_a = REF_W'(int'($urandom_range(160)) - 80);
         ref_b = REF_W'(int'($urandom_range(160)) - 80);
         ref_c = REF_W'(int'($urandom_range(160)) - 80);
         mod_idx = MI_W'($urandom_range(400));
         if (i % 7 == 3) hbridge_sel = ~hbridge_sel;
         if (i % 13 == 5) run_en = 1'b0;
         if (i % 13 == 6) run_en = 1'b1;
      end
      cyc(PERIOD);

      check_eq("R5 no leg overlap", overlap, 0);
      done = 1'b1;
      summary();
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         fails++;
         $display("FAIL R2 watchdog: actual=timeout expected=completion");
         summary();
         $finish;
      end
   end

endmodule